// File: doc/BRIEF.md
# Concurrent-Grant Request Bundler

This block lets several requesters share one upstream resource by collecting every request that is pending at the moment the resource is granted. All of those requesters are then served together under that single grant. Each requester and the resource use a dataless four-phase request/acknowledge handshake.

The block raises its resource request only when at least one requester is asking. It does not cycle the resource handshake while no requester is waiting. When the resource grant arrives, the block records which requesters are high in per-requester membership bits. It acknowledges all of them in the same cycle and exposes the recorded set as a bitmask. The resource request is withdrawn only after every member has dropped its request and seen its acknowledge return low. The result depends only on who is high at grant time, never on arrival order. A typical use is folding near-simultaneous increment and decrement events into one operation.

A requester that rises after the set has been recorded waits for the next resource cycle.

Top module: `req_bundler`

## Requirements
- R1: While reset (`rstN` low) is applied, `parentReq`, every bit of `childAck` and every bit of `bundleMask` are 0.
- R2: From the idle state, `parentReq` rises on the clock edge after a cycle in which at least one `childReq` bit is high. It stays low while all `childReq` bits are low.
- R3: On the first clock edge at which `parentReq` and `parentAck` are both high, every child whose `childReq` bit is high is acknowledged: its `childAck` bit rises on that edge. All such acknowledges rise together.
- R4: A child whose request is low at that edge is skipped. Its `childAck` bit stays 0 for the whole parent cycle, and it does not delay the parent handshake.
- R5: A child that raises its request after that edge is not acknowledged in the current parent cycle. It is acknowledged in the next parent cycle.
- R6: A member's `childAck` bit falls on the edge after a cycle in which its `childReq` bit is low. Its membership bit clears on the following edge.
- R7: `parentReq` falls on the edge after a cycle in which the recorded set has no remaining member. It never falls while any member is still acknowledged or still marked.
- R8: After `parentReq` falls, the block waits for `parentAck` to be low before it may raise `parentReq` again.
- R9: `bundleMask` equals the set of children acknowledged at the grant edge. It holds that value from that edge until the edge on which the block sees `parentAck` low after withdrawing its request. At all other times it is 0.
- R10: The recorded set is the same whatever order the requests arrived in before the grant.
- R11: No `childAck` bit rises unless `parentAck` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| childReq | input | NUM_CHILD | Per-child four-phase request |
| childAck | output | NUM_CHILD | Per-child four-phase acknowledge |
| parentReq | output | 1 | Request to the shared resource |
| parentAck | input | 1 | Grant from the shared resource |
| bundleMask | output | NUM_CHILD | Children recorded in the current bundle |

## Verification
The hardest case to reach from the ports is a child that arrives inside the short window after the grant has been taken but before the bundle has drained. Its request must be left waiting and then served on the next parent cycle. The stimulus delays the resource grant by several cycles and keeps the first child's request up for several cycles after its acknowledge. It starts the second child with a start delay chosen to fall inside that window. The bench then compares the parent-cycle index at which each child is first acknowledged. Order independence is checked by running the same pair of children in both arrival orders and comparing the recorded masks.

// File: rtl/req_bundler_pkg.sv
package req_bundler_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ASK   = 2'd1,
    PH_SERVE = 2'd2,
    PH_DROP  = 2'd3
  } phase_e;

  typedef struct packed {
    logic capture;
    logic clear;
  } ctlStrobes_t;
endpackage

// File: rtl/req_bundler_ctrl.sv
module req_bundler_ctrl
  import req_bundler_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        anyReq,
  input  logic        memberAny,
  input  logic        parentAck,
  output logic        parentReq,
  output ctlStrobes_t strb
);
  phase_e phase, phaseNext;
  logic   parentReqNext;

  always_comb begin
    strb.capture = (phase == PH_ASK) && parentAck;
    strb.clear   = (phase == PH_DROP) && !parentAck;
  end

  always_comb begin
    phaseNext     = phase;
    parentReqNext = parentReq;
    unique case (phase)
      PH_IDLE: begin
        if (anyReq) begin
          phaseNext     = PH_ASK;
          parentReqNext = 1'b1;
        end
      end
      PH_ASK: begin
        if (parentAck) begin
          if (anyReq) begin
            phaseNext = PH_SERVE;
          end else begin
            phaseNext     = PH_DROP;
            parentReqNext = 1'b0;
          end
        end
      end
      PH_SERVE: begin
        if (!memberAny) begin
          phaseNext     = PH_DROP;
          parentReqNext = 1'b0;
        end
      end
      PH_DROP: begin
        if (!parentAck) phaseNext = PH_IDLE;
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      parentReq <= 1'b0;
    end else begin
      phase     <= phaseNext;
      parentReq <= parentReqNext;
    end
  end

  // R2: the request to the resource rises only on a real child request
  a_r2_blocking_request: assert property (@(posedge clk) disable iff (!rstN)
    $rose(parentReq) |-> $past(anyReq));

  // R7: no withdrawal while any member is still marked
  a_r7_release_after_members: assert property (@(posedge clk) disable iff (!rstN)
    $fell(parentReq) |-> !$past(memberAny));

  // R8: a fresh request only after the previous grant was returned
  a_r8_grant_returned: assert property (@(posedge clk) disable iff (!rstN)
    $rose(parentReq) |-> !$past(parentAck));
endmodule

// File: rtl/req_bundler_datapath.sv
module req_bundler_datapath
  import req_bundler_pkg::*;
#(
  parameter int NUM_CHILD = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_CHILD-1:0] childReq,
  input  logic                 parentAck,
  input  ctlStrobes_t          strb,
  output logic [NUM_CHILD-1:0] childAck,
  output logic [NUM_CHILD-1:0] bundleMask,
  output logic                 memberAny,
  output logic                 anyReq
);
  logic [NUM_CHILD-1:0] memberBits;

  assign memberAny = |memberBits;
  assign anyReq    = |childReq;

  for (genvar i = 0; i < NUM_CHILD; i++) begin : g_child
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        childAck[i]   <= 1'b0;
        memberBits[i] <= 1'b0;
        bundleMask[i] <= 1'b0;
      end else if (strb.capture) begin
        childAck[i]   <= childReq[i];
        memberBits[i] <= childReq[i];
        bundleMask[i] <= childReq[i];
      end else begin
        childAck[i]   <= childAck[i] & childReq[i];
        memberBits[i] <= memberBits[i] & childAck[i];
        if (strb.clear) bundleMask[i] <= 1'b0;
      end
    end

    // R11: an acknowledge only ever rises under the resource grant
    a_r11_ack_needs_grant: assert property (@(posedge clk) disable iff (!rstN)
      $rose(childAck[i]) |-> parentAck);

    // R3: an acknowledge rises together with its bundle bit
    a_r3_ack_with_mask: assert property (@(posedge clk) disable iff (!rstN)
      $rose(childAck[i]) |-> $rose(bundleMask[i]));

    // R6: a released child loses its acknowledge on the next edge
    a_r6_ack_follows_release: assert property (@(posedge clk) disable iff (!rstN)
      (childAck[i] && !childReq[i]) |=> !childAck[i]);
  end
endmodule

// File: rtl/req_bundler.sv
module req_bundler
  import req_bundler_pkg::*;
#(
  parameter int NUM_CHILD = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_CHILD-1:0] childReq,
  output logic [NUM_CHILD-1:0] childAck,
  output logic                 parentReq,
  input  logic                 parentAck,
  output logic [NUM_CHILD-1:0] bundleMask
);
  ctlStrobes_t strb;
  logic        memberAny;
  logic        anyReq;

  req_bundler_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .anyReq    (anyReq),
    .memberAny (memberAny),
    .parentAck (parentAck),
    .parentReq (parentReq),
    .strb      (strb)
  );

  req_bundler_datapath #(.NUM_CHILD(NUM_CHILD)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .childReq   (childReq),
    .parentAck  (parentAck),
    .strb       (strb),
    .childAck   (childAck),
    .bundleMask (bundleMask),
    .memberAny  (memberAny),
    .anyReq     (anyReq)
  );
endmodule

// File: tb/tb_req_bundler.sv
module tb_req_bundler;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0] childReq = '0;
  logic [N-1:0] childAck;
  logic parentReq;
  logic parentAck = 1'b0;
  logic [N-1:0] bundleMask;

  always #4 clk = ~clk;

  req_bundler #(.NUM_CHILD(N)) dut (
    .clk(clk), .rstN(rstN), .childReq(childReq), .childAck(childAck),
    .parentReq(parentReq), .parentAck(parentAck), .bundleMask(bundleMask)
  );

  int compared = 0;
  int mismatched = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: phase 0 idle, 1 asking, 2 serving, 3 returning
  int mPh;
  bit mPreq;
  bit mAck[N];
  bit mMem[N];
  bit mSnap[N];

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPh = 0; mPreq = 0;
      for (int i = 0; i < N; i++) begin mAck[i] = 0; mMem[i] = 0; mSnap[i] = 0; end
    end else begin
      int live;
      int marked;
      bit oldAck[N];
      live = 0; marked = 0;
      for (int i = 0; i < N; i++) begin
        if (childReq[i]) live++;
        if (mMem[i]) marked++;
        oldAck[i] = mAck[i];
      end
      if (mPh == 1 && parentAck) begin
        for (int i = 0; i < N; i++) begin
          mAck[i] = childReq[i]; mMem[i] = childReq[i]; mSnap[i] = childReq[i];
        end
      end else begin
        for (int i = 0; i < N; i++) begin
          mAck[i] = oldAck[i] && childReq[i];
          mMem[i] = mMem[i] && oldAck[i];
        end
      end
      case (mPh)
        0: if (live > 0) begin mPh = 1; mPreq = 1; end
        1: if (parentAck) begin
             if (live > 0) mPh = 2;
             else begin mPh = 3; mPreq = 0; end
           end
        2: if (marked == 0) begin mPh = 3; mPreq = 0; end
        default: if (!parentAck) begin
             mPh = 0;
             for (int i = 0; i < N; i++) mSnap[i] = 0;
           end
      endcase
    end
  end

  // reactive environment settings
  int pend[N];
  int startDly[N];
  int holdDly[N];
  int holdCnt[N];
  int grantDly = 2;
  int grantCnt = 0;
  int parentCycles = 0;
  int firstAckCycle[N];
  logic [N-1:0] firstMask = '0;
  logic [N-1:0] prevMask = '0;
  logic prevPreq = 1'b0;
  int cycles = 0;
  bit envOn = 0;

  always @(negedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      mismatched++; compared++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
    if (envOn) begin
      logic [N-1:0] expAck;
      logic [N-1:0] expMask;
      for (int i = 0; i < N; i++) begin expAck[i] = mAck[i]; expMask[i] = mSnap[i]; end
      check("R2/R7/R8 parentReq", 32'(parentReq), 32'(mPreq));
      check("R3/R4/R6 childAck", 32'(childAck), 32'(expAck));
      check("R9 bundleMask", 32'(bundleMask), 32'(expMask));
      if ((|childAck) && !parentAck) check("R11 ack without grant", 32'(childAck), 32'h0);
      if (parentReq && !prevPreq) parentCycles++;
      prevPreq = parentReq;
      if (bundleMask != '0 && prevMask == '0 && firstMask == '0) firstMask = bundleMask;
      prevMask = bundleMask;
      for (int i = 0; i < N; i++)
        if (childAck[i] && firstAckCycle[i] < 0) firstAckCycle[i] = parentCycles;
      // parent agent
      if (parentReq && !parentAck) begin
        if (grantCnt < grantDly) grantCnt++;
        else begin parentAck = 1'b1; grantCnt = 0; end
      end else if (!parentReq && parentAck) parentAck = 1'b0;
      // child agents
      for (int i = 0; i < N; i++) begin
        if (!childReq[i] && !childAck[i] && pend[i] > 0) begin
          if (startDly[i] > 0) startDly[i]--;
          else childReq[i] = 1'b1;
        end else if (childReq[i] && childAck[i]) begin
          if (holdCnt[i] < holdDly[i]) holdCnt[i]++;
          else begin childReq[i] = 1'b0; holdCnt[i] = 0; pend[i]--; end
        end
      end
    end
  end

  task automatic setChild(input int i, input int cnt, input int st, input int hold);
    pend[i] = cnt; startDly[i] = st; holdDly[i] = hold; holdCnt[i] = 0;
  endtask

  task automatic runScenario(input int gd);
    int busy;
    grantDly = gd;
    firstMask = '0;
    parentCycles = 0;
    for (int i = 0; i < N; i++) firstAckCycle[i] = -1;
    busy = 1;
    while (busy != 0) begin
      @(posedge clk);
      busy = (parentReq || parentAck || childReq != '0) ? 1 : 0;
      for (int i = 0; i < N; i++) if (pend[i] > 0) busy = 1;
    end
    repeat (3) @(posedge clk);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin pend[i] = 0; startDly[i] = 0; holdDly[i] = 0; holdCnt[i] = 0; firstAckCycle[i] = -1; end
    repeat (3) @(negedge clk);
    check("R1 parentReq in reset", 32'(parentReq), 32'h0);
    check("R1 childAck in reset", 32'(childAck), 32'h0);
    check("R1 bundleMask in reset", 32'(bundleMask), 32'h0);
    rstN = 1'b1;
    envOn = 1;
    repeat (4) @(negedge clk);
    check("R2 no request while idle", 32'(parentReq), 32'h0);

    // single requester; the others are skipped (R4)
    setChild(2, 1, 0, 2);
    runScenario(2);
    check("R4 single bundle mask", 32'(firstMask), 32'h4);
    check("R4 skipped child 0", 32'(firstAckCycle[0]), 32'hFFFFFFFF);

    // all requesters at once
    for (int i = 0; i < N; i++) setChild(i, 1, 0, 1 + i);
    runScenario(3);
    check("R3 all bundled", 32'(firstMask), 32'hF);
    check("R3 one parent cycle", 32'(parentCycles), 32'h1);

    // staggered release lengths: parent waits for the slowest (R7)
    setChild(0, 1, 0, 1);
    setChild(3, 1, 0, 9);
    runScenario(1);
    check("R7 pair mask", 32'(firstMask), 32'h9);

    // late arrival during service
    setChild(1, 1, 0, 8);
    setChild(2, 1, 9, 1);
    runScenario(4);
    check("R5 early child in first cycle", 32'(firstAckCycle[1]), 32'h1);
    check("R5 late child in next cycle", 32'(firstAckCycle[2]), 32'h2);

    // symmetry: same pair, both arrival orders
    setChild(0, 1, 0, 2);
    setChild(3, 1, 1, 2);
    runScenario(5);
    check("R10 order A mask", 32'(firstMask), 32'h9);
    setChild(3, 1, 0, 2);
    setChild(0, 1, 1, 2);
    runScenario(5);
    check("R10 order B mask", 32'(firstMask), 32'h9);

    // repeated traffic back to back
    for (int i = 0; i < N; i++) setChild(i, 3, i, i);
    runScenario(0);
    check("R8 idle after traffic", 32'(parentReq), 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule